// File: doc/BRIEF.md
# Display I2C Write Target with Control-Byte Parser

This block sits between a two-wire serial bus and the command path of a character display controller. It oversamples the clock and data lines with the system clock and finds the start and stop conditions. It answers to one fixed 7-bit device address and only for write transfers. It pulls the data line low in the acknowledge slot of every byte it accepts.

Once addressed, the block splits the byte stream into pairs. Each pair is a register-select flag and a byte. A control byte carries a continuation flag in bit 7 and a register-select flag in bit 6. While the continuation flag is set, exactly one payload byte follows each control byte. The first control byte with the flag cleared switches the rest of the transfer to payload only, and every later byte takes that control byte's select flag. Each payload byte leaves the block as a single-cycle strobe together with its flag. A flag of 1 marks display RAM data and a flag of 0 marks an instruction for the decoder downstream.

Top module: `disp_i2c_wr_target`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `sda_pull_o` and `pay_vld_o` are 0.
- R2: A falling data line while the clock line is high begins a transfer. A rising data line while the clock line is high ends it. Data bits are taken only on a rising clock edge.
- R3: The first byte after a start is the address byte. The block acknowledges it only when bits 7..1 equal 7'b0111110 and bit 0 (read/write) is 0. For any other address it gives no acknowledge, and no later byte of that transfer is acknowledged or produces a strobe.
- R4: A matching address with bit 0 = 1 (a read) gets no acknowledge. No strobe follows, and the block never drives the bus for that transfer.
- R5: In the acknowledge slot of the address byte and of every later control or payload byte of an accepted transfer, `sda_pull_o` is 1 while SCL is high. It is raised only while SCL is low. It drops after the falling SCL edge that ends the acknowledge clock, and it is 0 outside acknowledge slots.
- R6: Bytes arrive most significant bit first, and a payload strobe carries the byte exactly as sent.
- R7: A control byte with bit 7 = 1 is followed by exactly one payload byte. That payload is tagged with the control byte's bit 6, and the byte after it is again a control byte.
- R8: After a control byte with bit 7 = 0, every byte up to the next stop or start is payload tagged with that control byte's bit 6, even when its own bit 7 or bit 6 is set.
- R9: Each payload byte gives `pay_vld_o` high for exactly one system clock, 2 to 6 system clocks after the rising SCL edge of its eighth bit reaches `scl_i`. Control and address bytes give no strobe.
- R10: A stop or repeated start at any point drops a partly received byte and resets the parser, so the next byte after the following address is a control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge); 0 releases it |
| pay_vld_o | output | 1 | One-cycle strobe for a payload byte |
| pay_rs_o | output | 1 | Select flag of the strobed byte: 1 display RAM, 0 instruction |
| pay_byte_o | output | 8 | Payload byte, valid with the strobe |

## Verification
The bench works on the parser's mode boundaries. It sends payload bytes that look like control bytes after a cleared continuation flag, and control bytes that look like payload while the flag is set. A parser that re-reads bit 7 in payload-only mode would swallow bytes or flip their flag. The bench also sends wrong and read-direction addresses, a stop in the middle of a byte, and a repeated start straight after payload-only mode. A design that keeps a partial byte or stale parser state would emit an extra strobe or misclassify the first byte of the next transfer. The acknowledge is sampled in every slot and the line is watched between slots, so an acknowledge that comes late, releases early, is missing or is given to a foreign address is caught.

// File: rtl/disp_i2c_pkg.sv
// Shared constants and state types for the display I2C write target.
// Assumes a byte-oriented bus with 7-bit addressing.
package disp_i2c_pkg;

    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 7;
    // Control byte fields the parser decodes.
    localparam int CO_BIT    = 7;
    localparam int RS_BIT    = 6;

    // Bit-engine phase within a transfer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // not addressed, ignore bus until START
        PH_ADDR = 2'd1,   // receiving address byte
        PH_DATA = 2'd2    // addressed, receiving stream bytes
    } eng_phase_e;

    // Control-stream parser state.
    typedef enum logic [1:0] {
        PS_CTRL = 2'd0,   // next byte is a control byte
        PS_ONE  = 2'd1,   // next byte is a single payload byte
        PS_ALL  = 2'd2    // all bytes are payload until STOP/START
    } parse_state_e;

endpackage

// File: rtl/disp_i2c_sync.sv
// Multi-stage synchroniser for asynchronous bus lines.
// Assumes idle-high lines; flops reset to 1 so no false edge leaves reset.
module disp_i2c_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_i,
    output logic [LINES-1:0] q_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_i[g]};
        end

        assign q_o[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/disp_i2c_bit_engine.sv
// Bit-level engine: detects START/STOP on synchronised lines, shifts bytes
// MSB first on SCL rise, matches the device address (write only), and
// drives the acknowledge from one SCL fall to the next.
// Assumes inputs already synchronised; no clock stretching.
module disp_i2c_bit_engine
    import disp_i2c_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h3E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    output logic              ack_pull,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q,
    output logic              frame_rst
);

    localparam int                CNT_W    = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]  BYTE_END = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  ACK_SLOT = CNT_W'(BYTE_W + 1);

    logic              scl_d, sda_d;
    logic              start_c, stop_c, rise_c, fall_c;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] nb;
    logic              addr_ok;
    eng_phase_e        phase;

    // Hold previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    // Classify line events: conditions while SCL high, clock edges.
    always_comb begin
        start_c = scl & scl_d & sda_d & ~sda;
        stop_c  = scl & scl_d & ~sda_d & sda;
        rise_c  = scl & ~scl_d;
        fall_c  = ~scl & scl_d;
        nb      = {sh[BYTE_W-2:0], sda};
        addr_ok = (nb[BYTE_W-1:1] == DEV_ADDR) && !nb[0];
    end

    // Transfer sequencing: bit count, shifting, address match, ACK drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            sh        <= '0;
            byte_q    <= '0;
            byte_vld  <= 1'b0;
            ack_pull  <= 1'b0;
            frame_rst <= 1'b0;
        end else begin
            byte_vld  <= 1'b0;
            frame_rst <= start_c | stop_c;
            if (start_c) begin
                phase    <= PH_ADDR;
                cnt      <= '0;
                ack_pull <= 1'b0;
            end else if (stop_c) begin
                phase    <= PH_IDLE;
                cnt      <= '0;
                ack_pull <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (rise_c && cnt < BYTE_END) begin
                    sh  <= nb;
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_BIT) begin
                        if (phase == PH_DATA) begin
                            byte_vld <= 1'b1;
                            byte_q   <= nb;
                        end else if (!addr_ok) begin
                            phase <= PH_IDLE;
                        end
                    end
                end else if (fall_c && cnt == BYTE_END) begin
                    cnt      <= ACK_SLOT;
                    ack_pull <= 1'b1;
                end else if (fall_c && cnt == ACK_SLOT) begin
                    cnt      <= '0;
                    ack_pull <= 1'b0;
                    if (phase == PH_ADDR) phase <= PH_DATA;
                end
            end
        end
    end

endmodule

// File: rtl/disp_i2c_ctl_parser.sv
// Control-stream parser: turns the byte stream after the address into
// (register-select, byte) payload strobes using each control byte's
// continuation and select bits.
// Assumes byte_vld only for bytes after an accepted address.
module disp_i2c_ctl_parser
    import disp_i2c_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              pay_vld,
    output logic              pay_rs,
    output logic [BYTE_W-1:0] pay_byte
);

    parse_state_e st;
    logic         rs_q;

    // Advance the control/payload sequence and emit payload strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= PS_CTRL;
            rs_q     <= 1'b0;
            pay_vld  <= 1'b0;
            pay_rs   <= 1'b0;
            pay_byte <= '0;
        end else begin
            pay_vld <= 1'b0;
            if (frame_rst) begin
                st <= PS_CTRL;
            end else if (byte_vld) begin
                case (st)
                    PS_CTRL: begin
                        rs_q <= byte_i[RS_BIT];
                        st   <= byte_i[CO_BIT] ? PS_ONE : PS_ALL;
                    end
                    PS_ONE: begin
                        pay_vld  <= 1'b1;
                        pay_rs   <= rs_q;
                        pay_byte <= byte_i;
                        st       <= PS_CTRL;
                    end
                    default: begin
                        pay_vld  <= 1'b1;
                        pay_rs   <= rs_q;
                        pay_byte <= byte_i;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/disp_i2c_wr_target.sv
// Top: write-only I2C target for a character display controller.
// Synchronises the bus, runs the bit engine and the control-byte parser.
// Assumes an external open-drain pad: sda_pull_o = 1 drives the line low.
module disp_i2c_wr_target
    import disp_i2c_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h3E,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              pay_vld_o,
    output logic              pay_rs_o,
    output logic [BYTE_W-1:0] pay_byte_o
);

    logic [1:0]        line_s;
    logic              eng_byte_vld;
    logic [BYTE_W-1:0] eng_byte;
    logic              frame_rst;

    disp_i2c_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    disp_i2c_bit_engine #(
        .DEV_ADDR (DEV_ADDR)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl       (line_s[1]),
        .sda       (line_s[0]),
        .ack_pull  (sda_pull_o),
        .byte_vld  (eng_byte_vld),
        .byte_q    (eng_byte),
        .frame_rst (frame_rst)
    );

    disp_i2c_ctl_parser u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_rst (frame_rst),
        .byte_vld  (eng_byte_vld),
        .byte_i    (eng_byte),
        .pay_vld   (pay_vld_o),
        .pay_rs    (pay_rs_o),
        .pay_byte  (pay_byte_o)
    );

endmodule

// File: rtl/disp_i2c_wr_target_chk.sv
// Property checker for disp_i2c_wr_target, bound to every instance.
// Watches the strobe, the acknowledge drive and the engine-to-parser link.
module disp_i2c_wr_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_pull_o,
    input logic pay_vld_o,
    input logic eng_byte_vld,
    input logic frame_rst
);

    // R9: payload strobe lasts one cycle
    a_r9_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld_o |=> !pay_vld_o);

    // R9: every strobe follows a byte delivered by the bit engine
    a_r9_strobe_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        pay_vld_o |-> $past(eng_byte_vld));

    // R5: acknowledge is raised only while SCL is low
    a_r5_ack_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_i);

    // R5: acknowledge level holds while SCL stays high
    a_r5_ack_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

    // R10: a START/STOP never lets a stale byte through
    a_r10_no_strobe_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst |=> !pay_vld_o);

endmodule

bind disp_i2c_wr_target disp_i2c_wr_target_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_i),
    .sda_pull_o   (sda_pull_o),
    .pay_vld_o    (pay_vld_o),
    .eng_byte_vld (eng_byte_vld),
    .frame_rst    (frame_rst)
);

// File: tb/tb_disp_i2c_wr_target.sv
// Bench: behavioural bus master plus a behavioural reference model of the
// expected acknowledges and payload strobes, compared on every clock.
module tb_disp_i2c_wr_target;

    localparam int H     = 16;      // SCL half period in system clocks
    localparam int Q     = 8;       // data setup before SCL rise
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic       pay_vld;
    logic       pay_rs;
    logic [7:0] pay_byte;

    int  checks = 0;
    int  errs = 0;
    int  cyc = 0;
    int  last_rise = 0;
    bit  ack_win = 1'b0;
    bit  prev_vld = 1'b0;
    bit  done = 1'b0;
    int  stray = 0;

    // Reference model state: 0 expect address, 1 control, 2 one payload,
    // 3 all payload, 4 ignore transfer.
    int         m_st = 4;
    bit         m_rs = 1'b0;
    logic [8:0] exp_q[$];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    disp_i2c_wr_target dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .pay_vld_o  (pay_vld),
        .pay_rs_o   (pay_rs),
        .pay_byte_o (pay_byte)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Per-clock comparison of strobes and stray drive against the model.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && pay_vld) begin
            if (prev_vld) check(1'b0, "R9", "strobe longer than one cycle", 1, 0);
            check((cyc - last_rise) >= 2 && (cyc - last_rise) <= 6, "R9",
                  "strobe latency", cyc - last_rise, 4);
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8", "unexpected strobe", {pay_rs, pay_byte}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                check({pay_rs, pay_byte} == e, "R6 R7 R8", "payload {rs,byte}",
                      {pay_rs, pay_byte}, e);
            end
        end
        prev_vld = pay_vld;
        if (rst_n && sda_pull && !ack_win && stray == 0) begin
            stray = 1;
            check(1'b0, "R5", "drive outside acknowledge slot", 1, 0);
        end
        if (cyc > LIMIT && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog", "run did not finish", cyc, LIMIT);
            finish_run();
        end
    end

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q); scl = 1'b1; w(H);
        sda_m = 1'b0; w(H); scl = 1'b0; w(Q);
        m_st = 0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q); scl = 1'b1; w(H);
        sda_m = 1'b1; w(H);
        m_st = 4;
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; w(Q); scl = 1'b1; w(H); scl = 1'b0; w(Q);
    endtask

    // Model step: returns the expected acknowledge and queues payload.
    task automatic model_byte(input logic [7:0] b, output bit exp_ack);
        exp_ack = 1'b1;
        case (m_st)
            0: if (b == 8'h7C) m_st = 1; else begin m_st = 4; exp_ack = 1'b0; end
            1: begin m_rs = b[6]; m_st = b[7] ? 2 : 3; end
            2: begin exp_q.push_back({m_rs, b}); m_st = 1; end
            3: exp_q.push_back({m_rs, b});
            default: exp_ack = 1'b0;
        endcase
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        bit exp_ack;
        model_byte(b, exp_ack);
        for (int i = 7; i >= 1; i--) send_bit(b[i]);
        sda_m = b[0]; w(Q); scl = 1'b1; last_rise = cyc; w(H);
        ack_win = 1'b1; scl = 1'b0; w(Q);
        sda_m = 1'b1; w(Q); scl = 1'b1; w(H / 2);
        check(sda_pull == exp_ack, req, "acknowledge in slot", sda_pull, exp_ack);
        w(H / 2); scl = 1'b0; w(6);
        check(sda_pull == 1'b0, "R5", "release after acknowledge clock", sda_pull, 0);
        ack_win = 1'b0; w(Q - 6);
    endtask

    task automatic drained(input string req);
        w(12);
        check(exp_q.size() == 0, req, "expected strobes outstanding", exp_q.size(), 0);
    endtask

    initial begin
        // R1: reset state
        w(4);
        check(sda_pull == 1'b0 && pay_vld == 1'b0, "R1", "outputs in reset",
              {sda_pull, pay_vld}, 0);
        rst_n = 1'b1; w(1);
        check(sda_pull == 1'b0 && pay_vld == 1'b0, "R1", "outputs after reset",
              {sda_pull, pay_vld}, 0);
        w(10);

        // R2 R3 R7 R8: mixed control words, then payload-only RAM data
        bus_start();
        send_byte(8'h7C, "R3");
        send_byte(8'h80, "R7"); send_byte(8'h38, "R7");
        send_byte(8'hC0, "R7"); send_byte(8'hA5, "R6");
        send_byte(8'h40, "R8"); send_byte(8'h48, "R8");
        send_byte(8'hC0, "R8"); send_byte(8'h81, "R8");
        bus_stop();
        drained("R8");

        // R8: payload-only instructions that look like control bytes
        bus_start();
        send_byte(8'h7C, "R3");
        send_byte(8'h00, "R8"); send_byte(8'h01, "R8");
        send_byte(8'h80, "R8"); send_byte(8'h40, "R8");
        bus_stop();
        drained("R8");

        // R7: continuation set, payload with bit7 = 0 must not end mode
        bus_start();
        send_byte(8'h7C, "R3");
        send_byte(8'hBF, "R7"); send_byte(8'h00, "R7");
        send_byte(8'hC0, "R7"); send_byte(8'h22, "R7");
        send_byte(8'h80, "R7"); send_byte(8'hFF, "R7");
        bus_stop();
        drained("R7");

        // R3: foreign addresses ignored, no acknowledge, no strobes
        bus_start();
        send_byte(8'h7E, "R3"); send_byte(8'h40, "R3"); send_byte(8'h31, "R3");
        bus_stop();
        bus_start();
        send_byte(8'h3C, "R3"); send_byte(8'h00, "R3");
        bus_stop();
        drained("R3");

        // R4: read direction at own address
        bus_start();
        send_byte(8'h7D, "R4"); send_byte(8'hC0, "R4"); send_byte(8'h55, "R4");
        bus_stop();
        drained("R4");

        // R10: STOP inside a payload byte drops it
        bus_start();
        send_byte(8'h7C, "R3"); send_byte(8'h40, "R10");
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        scl = 1'b0; bus_stop();
        drained("R10");
        bus_start();
        send_byte(8'h7C, "R3"); send_byte(8'h80, "R10"); send_byte(8'h12, "R10");
        bus_stop();
        drained("R10");

        // R10 R2: repeated START after payload-only mode resets parser
        bus_start();
        send_byte(8'h7C, "R3"); send_byte(8'h40, "R10"); send_byte(8'h55, "R10");
        bus_start();
        send_byte(8'h7C, "R3"); send_byte(8'h80, "R10"); send_byte(8'h11, "R10");
        send_byte(8'h00, "R10"); send_byte(8'h0C, "R10");
        bus_stop();
        drained("R10");

        check(stray == 0, "R5", "no drive between slots", stray, 0);
        done = 1'b1;
        finish_run();
    end

endmodule